// File: doc/BRIEF.md
# Selectable-Timeout Strobe Watchdog

This block guards a processor that is expected to pulse a strobe line at regular intervals. It counts a slow timebase tick (nominally one millisecond) and raises a one-clock timeout request when no valid strobe arrives within the selected window. A downstream reset generator takes that request, asserts system reset and applies its own hold time. The watchdog feeds the current reset state back into this block, and the count is held at zero for as long as that reset stays active.

Only a falling edge of the strobe counts as a valid strobe. The strobe is brought into the clock domain through a two-flop synchronizer, and its edge is detected on the synchronized value. The window comes from a 2-bit select code that stands for a pin tied low, left open or tied high. The sensing circuit for that pin sits outside this block. The select is captured each time the count restarts, so a change in the middle of a window takes effect at the next restart. With one-millisecond ticks the default limits give the typical windows of 150, 600 and 1200 ms.

Top module: `strobe_watchdog`

## Requirements
- R1: With select code 2'b00 the request fires after exactly LIM_LOW ticks since the last restart, with 2'b01 after LIM_OPEN ticks, and with 2'b10 after LIM_HIGH ticks.
- R2: A high-to-low transition of the strobe restarts the count from zero. A rising edge, or a strobe held at a steady level, leaves the count running.
- R3: While the reset-active input is high, the count is held at zero and no request is issued, whatever the ticks do.
- R4: When the count expires it returns to zero and timing starts again at once, so an unserviced watchdog requests again after each further full window.
- R5: A strobe low pulse lasting one clock period is accepted as a valid strobe.
- R6: The unused select code 2'b11 gives the same window as 2'b10.
- R7: The select is captured only when the count restarts (strobe fall, reset active or expiry). A change at any other time leaves the current window unchanged.
- R8: The request is exactly one clock wide and rises on the clock edge that samples the expiring tick.
- R9: After the block reset the request output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| strobe_i | input | 1 | Processor strobe, asynchronous, idle high |
| win_sel_i | input | 2 | Window select: 00 low, 01 open, 10 high, 11 as high |
| rst_active_i | input | 1 | High while system reset is asserted |
| tick_i | input | 1 | One-cycle timebase pulse |
| timeout_o | output | 1 | One-cycle timeout request |

## Verification
The bench builds the block with limits of 5, 9 and 14 ticks instead of 150, 600 and 1200. With these values every window, the re-arm after an expiry and the choice of window for each select code can be reached within a few hundred cycles. The limits differ from one another, so a wrong decode or a select captured at the wrong moment changes the count of requests that the bench observes.

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int LIM_LOW  = 150,
  parameter int LIM_OPEN = 600,
  parameter int LIM_HIGH = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_i,
  input  logic [1:0] win_sel_i,
  input  logic       rst_active_i,
  input  logic       tick_i,
  output logic       timeout_o
);
  localparam int MAX_LIM = (LIM_HIGH > LIM_OPEN) ?
                           ((LIM_HIGH > LIM_LOW) ? LIM_HIGH : LIM_LOW) :
                           ((LIM_OPEN > LIM_LOW) ? LIM_OPEN : LIM_LOW);
  localparam int CW = $clog2(MAX_LIM + 1);

  logic          s_meta, s_sync, s_prev;
  logic          strobe_fall;
  logic [CW-1:0] cnt_q, lim_q, sel_lim;
  logic          expire, restart, timeout_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s_meta, s_sync, s_prev} <= 3'b111;
    else        {s_meta, s_sync, s_prev} <= {strobe_i, s_meta, s_sync};

  assign strobe_fall = s_prev & ~s_sync;

  always_comb
    case (win_sel_i)
      2'b00:   sel_lim = CW'(LIM_LOW);
      2'b01:   sel_lim = CW'(LIM_OPEN);
      default: sel_lim = CW'(LIM_HIGH);
    endcase

  assign expire  = tick_i && (cnt_q == lim_q - CW'(1));
  assign restart = rst_active_i || strobe_fall || expire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q     <= '0;
      lim_q     <= CW'(LIM_HIGH);
      timeout_q <= 1'b0;
    end else begin
      timeout_q <= expire && !rst_active_i && !strobe_fall;
      if (restart) begin
        cnt_q <= '0;
        lim_q <= sel_lim;
      end else if (tick_i) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end

  assign timeout_o = timeout_q;
endmodule

// File: rtl/strobe_watchdog_chk.sv
module strobe_watchdog_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_active_i,
  input logic          tick_i,
  input logic          timeout_o,
  input logic          strobe_fall,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] lim_q
);
  p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  p_quiet_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active_i |=> (!timeout_o && cnt_q == '0));

  p_fire_needs_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !timeout_o);

  p_count_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim_q);

  p_fall_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_fall |=> (cnt_q == '0 && !timeout_o));

  p_expiry_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> cnt_q == '0);
endmodule

bind strobe_watchdog strobe_watchdog_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_active_i(rst_active_i), .tick_i(tick_i),
  .timeout_o(timeout_o), .strobe_fall(strobe_fall), .cnt_q(cnt_q), .lim_q(lim_q)
);

// File: tb/tb_strobe_watchdog.sv
module tb_strobe_watchdog;
  localparam int L0 = 5, L1 = 9, L2 = 14;

  logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b1, rsta = 1'b0, tick = 1'b0;
  logic [1:0] sel = 2'b00;
  logic timeout;
  int checks = 0, fails = 0, pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  strobe_watchdog #(.LIM_LOW(L0), .LIM_OPEN(L1), .LIM_HIGH(L2)) dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .win_sel_i(sel),
    .rst_active_i(rsta), .tick_i(tick), .timeout_o(timeout));

  // sel, ticks, expected requests
  localparam int VEC [8][3] = '{
    '{0, 4, 0}, '{0, 5, 1}, '{1, 8, 0}, '{1, 9, 1},
    '{2, 13, 0}, '{2, 14, 1}, '{3, 14, 1}, '{0, 10, 2}};

  task automatic step();
    @(negedge clk);
    if (timeout) pulses++;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(); tick = 1'b0;
      for (int j = 0; j < 3; j++) step();
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] s);
    sel = s; rsta = 1'b1; step(); step(); rsta = 1'b0; step(); pulses = 0;
  endtask

  task automatic strobe_low(input int cyc);
    strobe = 1'b0;
    for (int i = 0; i < cyc; i++) step();
    strobe = 1'b1;
    for (int i = 0; i < 4; i++) step();
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    check("R9 reset state", int'(timeout), 0);
    rst_n = 1'b1; step();

    for (int v = 0; v < 8; v++) begin
      restart(2'(VEC[v][0]));
      ticks(VEC[v][1]);
      check($sformatf("R1/R4/R6/R8 vec%0d", v), pulses, VEC[v][2]);
    end

    // R3: ticks during reset are ignored
    sel = 2'b00; rsta = 1'b1; pulses = 0;
    ticks(12);
    check("R3 no request in reset", pulses, 0);
    rsta = 1'b0; step(); pulses = 0;
    ticks(4);
    check("R3 count held at zero", pulses, 0);
    ticks(1);
    check("R3 full window after release", pulses, 1);

    // R2: falling edge restarts, rising edge does not
    restart(2'b00);
    ticks(3);
    strobe = 1'b0; for (int i = 0; i < 4; i++) step();
    ticks(4);
    check("R2 fall restarts", pulses, 0);
    strobe = 1'b1; for (int i = 0; i < 4; i++) step();
    ticks(1);
    check("R2 rise ignored", pulses, 1);

    // R5: single-clock low pulse
    restart(2'b00);
    ticks(4);
    strobe_low(1);
    ticks(4);
    check("R5 short pulse restarts", pulses, 0);
    ticks(1);
    check("R5 window after short pulse", pulses, 1);

    // R7: select captured only at restart
    restart(2'b00);
    ticks(1);
    sel = 2'b10;
    ticks(3);
    check("R7 before expiry", pulses, 0);
    ticks(1);
    check("R7 old window kept", pulses, 1);
    pulses = 0;
    ticks(13);
    check("R7 new window after expiry", pulses, 0);
    ticks(1);
    check("R7 new window fires", pulses, 1);

    // R8: request one cycle wide
    restart(2'b00);
    ticks(4);
    tick = 1'b1; step(); tick = 1'b0;
    check("R8 not before edge", int'(timeout), 1);
    step();
    check("R8 one cycle wide", int'(timeout), 0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 50000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule